// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog with a small register-mapped control port. Software programs a timeout length in ticks, writes the reload register to start a fresh countdown, and controls counting with a halt bit. An external `tick_i` strobe, which is produced by a prescaler outside this block, advances the count. One tick is nominally 0.6 s, so a timeout of N seconds is programmed as N*10/6 ticks.

When the countdown runs out for the first time, a timeout flag is raised and the counter restarts from the programmed value. If it runs out again with no reload in between, the block raises a second-stage flag and a boot flag. It also issues a one-cycle reset request, unless the `no_reboot_i` strap is high. The register map also provides two mailbox bytes, two message bytes, a count byte, a software-interrupt byte and a second control word. Writing either mailbox byte raises a status bit. Status flags are write-one-to-clear, and the lock bit stays set once written.

All writes take effect on the rising clock edge. A read registers the addressed value at the edge where `bus_sel_i` is high and `bus_we_i` is low. That value shows the state before the edge and appears on `bus_rdata_o` after the edge.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, every register reads zero except: control B (offset 6) reads 0x0008, the software-interrupt byte (offset 10) reads 0x0003, and the timeout value (offset 11) reads 0x0004.
- R2: Any write to the count register (offset 0) loads the countdown from the timeout value. A read of offset 0 returns the current count. While running, each tick lowers the count by one.
- R3: Bit 0 of control A (offset 5) is the halt bit. While it is 1, ticks leave the count unchanged. Writing it back to 0 resumes counting from the held value.
- R4: The timeout value keeps only its low TMR_W bits (10 by default), so a write of 0xFFFF reads back 0x03FF. When loaded with that maximum, the count reads 1 and the timeout flag is still clear after 1022 ticks. The flag is set after tick 1023.
- R5: An expiry is a tick that arrives while running with a count of 1 or 0. An expiry sets bit 0 of status A (offset 3) and reloads the count from the timeout value.
- R6: The second expiry with no reload between the two sets bits 0 (second stage) and 1 (boot) of status B (offset 4). When `no_reboot_i` is low, it also drives `rst_req_o` high for exactly one cycle, in the cycle after the expiry edge. The next expiry after that counts as a first expiry again.
- R7: When `no_reboot_i` is high, a second expiry still sets both status B bits but produces no reset request.
- R8: A count-register write, or a control-A write with bit 0 set, made between two expiries cancels the pending second stage. The next expiry then leaves status B at zero.
- R9: Status A and status B bits clear only where a 1 is written, and a written 0 leaves them set. Writing back the value read clears the register to zero.
- R10: A write to mailbox-in (offset 1) stores the low byte and sets status A bit 1. A write to mailbox-out (offset 2) stores the low byte and sets status A bit 2.
- R11: Bit 1 of control A is a lock bit. Once it is written 1, later writes of 0 leave it set until reset.
- R12: Control B (offset 6) stores all 16 bits. The message bytes (offsets 7 and 8), the count byte (offset 9) and the software-interrupt byte (offset 10) store only their low 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle countdown strobe from the prescaler |
| no_reboot_i | input | 1 | Strap that suppresses the second-stage reset request |
| bus_sel_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Register offset |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| rst_req_o | output | 1 | One-cycle reset request on second expiry |

## Verification
The properties assume that `tick_i`, `no_reboot_i` and the bus inputs are synchronous to the clock and known once reset is released. They also assume that a single bus access is made per cycle. The countdown properties hold even when a tick coincides with a reload or a halt write. The stimulus drives every input on the falling edge and holds ticks to one cycle with an idle cycle after each. It never issues a tick during a register access, so each read reflects a settled count and settled flags.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned ADDR_W    = 4;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned NUM_OFS   = 12;
  localparam int unsigned NUM_STORE = 7;

  localparam logic [ADDR_W-1:0] OFS_COUNT   = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_MBX_IN  = 4'd1;
  localparam logic [ADDR_W-1:0] OFS_MBX_OUT = 4'd2;
  localparam logic [ADDR_W-1:0] OFS_STAT_A  = 4'd3;
  localparam logic [ADDR_W-1:0] OFS_STAT_B  = 4'd4;
  localparam logic [ADDR_W-1:0] OFS_CTRL_A  = 4'd5;
  localparam logic [ADDR_W-1:0] OFS_CTRL_B  = 4'd6;
  localparam logic [ADDR_W-1:0] OFS_MSG_A   = 4'd7;
  localparam logic [ADDR_W-1:0] OFS_MSG_B   = 4'd8;
  localparam logic [ADDR_W-1:0] OFS_WDCNT   = 4'd9;
  localparam logic [ADDR_W-1:0] OFS_SWIRQ   = 4'd10;
  localparam logic [ADDR_W-1:0] OFS_TIMER   = 4'd11;

  // Plain storage registers, indexed 0..NUM_STORE-1
  function automatic logic [ADDR_W-1:0] store_ofs(input int idx);
    case (idx)
      0:       return OFS_MBX_IN;
      1:       return OFS_MBX_OUT;
      2:       return OFS_CTRL_B;
      3:       return OFS_MSG_A;
      4:       return OFS_MSG_B;
      5:       return OFS_WDCNT;
      default: return OFS_SWIRQ;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] store_rst(input int idx);
    case (idx)
      2:       return 16'h0008;
      6:       return 16'h0003;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] store_mask(input int idx);
    return (idx == 2) ? 16'hFFFF : 16'h00FF;
  endfunction

  // Write-one-to-clear with set taking priority
  function automatic logic [2:0] w1c_a(input logic [2:0] cur, input logic [2:0] clr,
                                       input logic [2:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/wdog_bus_decode.sv
module wdog_bus_decode
  import wdog_pkg::*;
(
  input  logic                sel_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_OFS-1:0]  wr_hit_o,
  output logic                rd_en_o
);
  for (genvar g = 0; g < NUM_OFS; g++) begin : g_hit
    assign wr_hit_o[g] = sel_i & we_i & (addr_i == ADDR_W'(g));
  end
  assign rd_en_o = sel_i & ~we_i;
endmodule

// File: rtl/wdog_store_reg.sv
module wdog_store_reg #(
  parameter int unsigned        WIDTH = 16,
  parameter logic [WIDTH-1:0]   RST   = '0,
  parameter logic [WIDTH-1:0]   MASK  = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= RST;
    else if (wr_en_i) q_o <= wdata_i & MASK;
  end
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
  parameter int unsigned TMR_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             halt_i,
  input  logic             load_i,
  input  logic [TMR_W-1:0] tmr_val_i,
  output logic [TMR_W-1:0] count_o,
  output logic             expire_o
);
  function automatic logic [TMR_W-1:0] next_count(input logic [TMR_W-1:0] cur,
                                                   input logic [TMR_W-1:0] tv,
                                                   input logic ld, input logic run_tick);
    if (ld)                               return tv;
    if (run_tick && cur <= TMR_W'(1))     return tv;
    if (run_tick)                         return cur - TMR_W'(1);
    return cur;
  endfunction

  logic run_tick_w;
  assign run_tick_w = tick_i & ~halt_i;
  assign expire_o   = run_tick_w & ~load_i & (count_o <= TMR_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_o <= '0;
    else         count_o <= next_count(count_o, tmr_val_i, load_i, run_tick_w);
  end
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       expire_i,
  input  logic       cancel_i,
  input  logic       no_reboot_i,
  input  logic [2:0] set_a_i,
  input  logic [2:0] clr_a_i,
  input  logic [1:0] clr_b_i,
  output logic [2:0] stat_a_o,
  output logic [1:0] stat_b_o,
  output logic       second_o,
  output logic       rst_req_o
);
  import wdog_pkg::*;

  logic armed_q;

  assign second_o = expire_i & armed_q & ~cancel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      stat_a_o  <= '0;
      stat_b_o  <= '0;
      rst_req_o <= 1'b0;
    end else begin
      if (cancel_i)      armed_q <= 1'b0;
      else if (expire_i) armed_q <= ~armed_q;
      stat_a_o  <= w1c_a(stat_a_o, clr_a_i, {set_a_i[2:1], set_a_i[0] | expire_i});
      stat_b_o  <= (stat_b_o & ~clr_b_i) | {2{second_o}};
      rst_req_o <= second_o & ~no_reboot_i;
    end
  end
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int unsigned TMR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              no_reboot_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              rst_req_o
);
  localparam logic [TMR_W-1:0] TIMER_RST = TMR_W'(4);

  logic [NUM_OFS-1:0] wr_hit_w;
  logic               rd_en_w;
  logic               load_w, cancel_w, expire_w, second_w;
  logic               halt_q, lock_q;
  logic [TMR_W-1:0]   timer_q, count_q;
  logic [2:0]         stat_a_q, set_a_w, clr_a_w;
  logic [1:0]         stat_b_q, clr_b_w;
  logic [DATA_W-1:0]  store_q [NUM_STORE];
  logic [DATA_W-1:0]  rd_mux;

  wdog_bus_decode u_dec (
    .sel_i(bus_sel_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wr_hit_o(wr_hit_w), .rd_en_o(rd_en_w)
  );

  for (genvar g = 0; g < NUM_STORE; g++) begin : g_store
    wdog_store_reg #(
      .WIDTH(DATA_W), .RST(store_rst(g)), .MASK(store_mask(g))
    ) u_reg (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .wr_en_i(wr_hit_w[store_ofs(g)]),
      .wdata_i(bus_wdata_i), .q_o(store_q[g])
    );
  end

  // Control A: halt follows writes, lock only accumulates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q <= 1'b0;
      lock_q <= 1'b0;
    end else if (wr_hit_w[OFS_CTRL_A]) begin
      halt_q <= bus_wdata_i[0];
      lock_q <= lock_q | bus_wdata_i[1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     timer_q <= TIMER_RST;
    else if (wr_hit_w[OFS_TIMER])    timer_q <= bus_wdata_i[TMR_W-1:0];
  end

  assign load_w   = wr_hit_w[OFS_COUNT];
  assign cancel_w = load_w | (wr_hit_w[OFS_CTRL_A] & bus_wdata_i[0]);

  wdog_countdown #(.TMR_W(TMR_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .halt_i(halt_q),
    .load_i(load_w), .tmr_val_i(timer_q), .count_o(count_q), .expire_o(expire_w)
  );

  assign set_a_w = {wr_hit_w[OFS_MBX_OUT], wr_hit_w[OFS_MBX_IN], 1'b0};
  assign clr_a_w = wr_hit_w[OFS_STAT_A] ? bus_wdata_i[2:0] : 3'b000;
  assign clr_b_w = wr_hit_w[OFS_STAT_B] ? bus_wdata_i[1:0] : 2'b00;

  wdog_stage u_stage (
    .clk_i(clk_i), .rst_ni(rst_ni), .expire_i(expire_w), .cancel_i(cancel_w),
    .no_reboot_i(no_reboot_i), .set_a_i(set_a_w), .clr_a_i(clr_a_w),
    .clr_b_i(clr_b_w), .stat_a_o(stat_a_q), .stat_b_o(stat_b_q),
    .second_o(second_w), .rst_req_o(rst_req_o)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr_i)
      OFS_COUNT:  rd_mux = DATA_W'(count_q);
      OFS_STAT_A: rd_mux = DATA_W'(stat_a_q);
      OFS_STAT_B: rd_mux = DATA_W'(stat_b_q);
      OFS_CTRL_A: rd_mux = DATA_W'({lock_q, halt_q});
      OFS_TIMER:  rd_mux = DATA_W'(timer_q);
      default:    rd_mux = '0;
    endcase
    for (int i = 0; i < NUM_STORE; i++)
      if (bus_addr_i == store_ofs(i)) rd_mux = store_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bus_rdata_o <= '0;
    else if (rd_en_w) bus_rdata_o <= rd_mux;
  end
endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk #(
  parameter int unsigned TMR_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             no_reboot_i,
  input logic             rst_req_o,
  input logic             load_w,
  input logic             expire_w,
  input logic             second_w,
  input logic             halt_q,
  input logic             lock_q,
  input logic [TMR_W-1:0] count_q,
  input logic [TMR_W-1:0] timer_q,
  input logic [2:0]       stat_a_q,
  input logic [1:0]       stat_b_q
);
  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_w |=> count_q == $past(timer_q));

  p_tick_dec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !halt_q && !load_w && count_q > TMR_W'(1))
      |=> count_q == TMR_W'($past(count_q) - TMR_W'(1)));

  p_halt_freeze_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_q && !load_w) |=> $stable(count_q));

  p_expire_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_w |=> stat_a_q[0]);

  p_second_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    second_w |=> stat_b_q == 2'b11);

  p_pulse_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  p_pulse_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(second_w));

  p_noreboot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (second_w && no_reboot_i) |=> !rst_req_o);

  p_lock_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);
endmodule

bind wdog_two_stage wdog_two_stage_chk #(.TMR_W(TMR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .no_reboot_i(no_reboot_i),
  .rst_req_o(rst_req_o), .load_w(load_w), .expire_w(expire_w),
  .second_w(second_w), .halt_q(halt_q), .lock_q(lock_q), .count_q(count_q),
  .timer_q(timer_q), .stat_a_q(stat_a_q), .stat_b_q(stat_b_q)
);

// File: tb/wdog_two_stage_test.sv
`timescale 1ns/1ps
module wdog_two_stage_test;
  localparam logic [3:0] A_CNT = 4'd0, A_MIN = 4'd1, A_MOUT = 4'd2, A_STA = 4'd3,
                         A_STB = 4'd4, A_CTA = 4'd5, A_CTB = 4'd6, A_MSA = 4'd7,
                         A_MSB = 4'd8, A_WDC = 4'd9, A_SWI = 4'd10, A_TMR = 4'd11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        no_reboot = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rst_req;

  int checks = 0, errors = 0, pulses = 0;
  bit done = 1'b0;

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t sb[$];
  item_t cur;

  always #2 clk = ~clk;

  wdog_two_stage uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .no_reboot_i(no_reboot),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .rst_req_o(rst_req)
  );

  // Monitor: compares each registered read against the queued expectation
  always begin
    @(posedge clk);
    if (sel && !we) begin
      #1;
      cur = sb.pop_front();
      checks++;
      if (rdata !== cur.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", cur.tag, rdata, cur.exp);
      end
    end
  end

  always begin
    @(posedge clk);
    #1;
    if (rst_req) pulses++;
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] e, input string tag);
    item_t it;
    @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
    it.exp = e; it.tag = tag; sb.push_back(it);
    @(negedge clk); sel = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd(A_CNT, 16'h0000, "R1 count");   rd(A_MIN, 16'h0000, "R1 mbx_in");
    rd(A_MOUT, 16'h0000, "R1 mbx_out"); rd(A_STA, 16'h0000, "R1 stat_a");
    rd(A_STB, 16'h0000, "R1 stat_b");   rd(A_CTA, 16'h0000, "R1 ctrl_a");
    rd(A_CTB, 16'h0008, "R1 ctrl_b");   rd(A_MSA, 16'h0000, "R1 msg_a");
    rd(A_MSB, 16'h0000, "R1 msg_b");    rd(A_WDC, 16'h0000, "R1 wdcnt");
    rd(A_SWI, 16'h0003, "R1 swirq");    rd(A_TMR, 16'h0004, "R1 timer");

    // R2/R3 load, halt, resume
    wr(A_CTA, 16'h0001); wr(A_TMR, 16'd5); wr(A_CNT, 16'h0000);
    rd(A_CNT, 16'd5, "R2 load");
    ticks(2);
    rd(A_CNT, 16'd5, "R3 halted");
    wr(A_CTA, 16'h0000); ticks(2);
    rd(A_CNT, 16'd3, "R2 decrement");
    ticks(2);
    rd(A_CNT, 16'd1, "R2 count one"); rd(A_STA, 16'h0000, "R5 not yet");
    ticks(1);
    rd(A_STA, 16'h0001, "R5 first expiry"); rd(A_CNT, 16'd5, "R5 reload");

    // R9 write-one-to-clear
    wr(A_STA, 16'h0000); rd(A_STA, 16'h0001, "R9 zero keeps");
    wr(A_STA, 16'h0001); rd(A_STA, 16'h0000, "R9 one clears");

    // R6 second expiry with reset request
    ticks(5);
    rd(A_STB, 16'h0003, "R6 stat_b"); rd(A_STA, 16'h0001, "R6 stat_a");
    chk("R6 pulses", pulses, 1);
    wr(A_STB, 16'h0003); wr(A_STA, 16'h0001);
    rd(A_STB, 16'h0000, "R9 writeback b");

    // R7 strap suppresses request
    no_reboot = 1'b1;
    ticks(5); rd(A_STB, 16'h0000, "R6 stage rearmed");
    ticks(5); rd(A_STB, 16'h0003, "R7 stat_b");
    chk("R7 no pulse", pulses, 1);
    wr(A_STB, 16'h0003); wr(A_STA, 16'h0001);
    no_reboot = 1'b0;

    // R8 reload and halt cancel pending stage
    ticks(5); wr(A_CNT, 16'h0000); ticks(5);
    rd(A_STB, 16'h0000, "R8 reload cancels");
    wr(A_CTA, 16'h0001); wr(A_CTA, 16'h0000); ticks(5);
    rd(A_STB, 16'h0000, "R8 halt cancels");
    chk("R8 no pulse", pulses, 1);
    wr(A_STA, 16'h0001); wr(A_CTA, 16'h0001);

    // R4 maximum timeout
    wr(A_TMR, 16'hFFFF); rd(A_TMR, 16'h03FF, "R4 mask");
    wr(A_CNT, 16'h0000); wr(A_CTA, 16'h0000);
    ticks(1022);
    rd(A_CNT, 16'd1, "R4 count one"); rd(A_STA, 16'h0000, "R4 no flag");
    ticks(1);
    rd(A_STA, 16'h0001, "R4 flag");
    wr(A_CTA, 16'h0001); wr(A_STA, 16'h0001);

    // R10 mailboxes
    wr(A_MIN, 16'h01A5); rd(A_MIN, 16'h00A5, "R10 mbx_in data");
    rd(A_STA, 16'h0002, "R10 in flag");
    wr(A_MOUT, 16'h003C); rd(A_MOUT, 16'h003C, "R10 mbx_out data");
    rd(A_STA, 16'h0006, "R10 out flag");
    wr(A_STA, 16'h0006); rd(A_STA, 16'h0000, "R9 writeback a");

    // R11 sticky lock
    wr(A_CTA, 16'h0003); rd(A_CTA, 16'h0003, "R11 set");
    wr(A_CTA, 16'h0001); rd(A_CTA, 16'h0003, "R11 held");
    wr(A_CTA, 16'h0000); rd(A_CTA, 16'h0002, "R11 halt clears only");

    // R12 storage widths
    wr(A_CTB, 16'h1234); rd(A_CTB, 16'h1234, "R12 ctrl_b");
    wr(A_MSA, 16'h0155); rd(A_MSA, 16'h0055, "R12 msg_a");
    wr(A_MSB, 16'hAAAA); rd(A_MSB, 16'h00AA, "R12 msg_b");
    wr(A_WDC, 16'h01FF); rd(A_WDC, 16'h00FF, "R12 wdcnt");
    wr(A_SWI, 16'h0000); rd(A_SWI, 16'h0000, "R12 swirq");

    repeat (4) @(negedge clk);
    chk("scoreboard drained", sb.size(), 0);
    finish_run();
  end
endmodule